// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Decimal Adjust

This block is the arithmetic and logic datapath of a small accumulator-based controller. Each cycle it receives the accumulator byte, a second operand byte (a memory location or an immediate literal), a 4-bit operation code and the current carry, digit-carry and zero flags. It returns a result byte, the next value of each flag, and a skip request.

The skip request belongs to the increment-and-skip and decrement-and-skip operations. The surrounding controller decides whether the result is written back to the accumulator or to the memory operand. The datapath itself is combinational.

A registered copy of the three flags is also produced. A parameter chooses between a flop stage and a plain wire for this copy.

Top module: `acc_alu8`

## Requirements
- R1: Code 0 (add) returns acc+opnd modulo 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is 1 exactly when the result is 0.
- R2: Code 1 (reverse subtract) returns opnd-acc modulo 256. C=1 when opnd>=acc (no borrow), DC=1 when opnd[3:0]>=acc[3:0], and Z reflects the result.
- R3: Codes 2, 3, 4 and 5 return acc AND opnd, acc OR opnd, acc XOR opnd and NOT opnd. They update Z only; C and DC pass through unchanged.
- R4: Codes 6 and 7 return opnd+1 and opnd-1, wrapping modulo 256. They update Z only.
- R5: Codes 8 and 9 return opnd+1 and opnd-1. skip_o is 1 exactly when that result is 0, and all three flags pass through unchanged.
- R6: Code 10 rotates left through carry: the result is {opnd[6:0],c_i} and C becomes opnd[7]. Code 11 rotates right through carry: the result is {c_i,opnd[7:1]} and C becomes opnd[0]. DC and Z are unchanged.
- R7: Code 12 swaps the nibbles of opnd, so the result is {opnd[3:0],opnd[7:4]}. No flag changes.
- R8: Code 13 (decimal adjust on acc) first adds 0x06 to the whole byte when acc[3:0]>9 or dc_i=1. It then adds 0x60 when the upper nibble of that sum is above 9 or c_i=1. DC and Z are unchanged.
- R9: For code 13, C is 1 when c_i was 1 or when either correction carries out of bit 7. A carry that was already set is never cleared.
- R10: Codes 14 and 15 are reserved. They return acc, pass all flags through and hold skip_o at 0.
- R11: skip_o is 0 for every code other than 8 and 9.
- R12: With REG_FLAGS=1, the outputs fq_c_o, fq_dc_o and fq_z_o are 0 during reset. After reset, each one equals the value of c_o, dc_o or z_o at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered flag copy |
| rst_n | input | 1 | Active-low asynchronous reset of the flag copy |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Memory operand or immediate literal |
| c_i | input | 1 | Current carry flag |
| dc_i | input | 1 | Current digit-carry flag |
| z_i | input | 1 | Current zero flag |
| res_o | output | 8 | Result byte |
| c_o | output | 1 | Next carry flag |
| dc_o | output | 1 | Next digit-carry flag |
| z_o | output | 1 | Next zero flag |
| skip_o | output | 1 | Skip request for the increment/decrement-and-skip operations |
| fq_c_o | output | 1 | Registered carry |
| fq_dc_o | output | 1 | Registered digit-carry |
| fq_z_o | output | 1 | Registered zero |

## Verification
The datapath holds no state, so a wrong flag-update mask or a wrong correction term shows on res_o or on the flag outputs in the same cycle the operands are applied. The registered flag copy is the only storage. A fault there shows one clock edge later as a mismatch against the flags of the previous vector. Random vectors cover every operation code with random flag inputs. Directed vectors cover the nibble and byte carry boundaries, the borrow edges of the subtraction, the decimal-adjust cases where a correction overflows, and the skip condition when the operand wraps to zero.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   localparam int OP_W = 4;

   localparam logic [OP_W-1:0] OP_ADD   = 4'd0;
   localparam logic [OP_W-1:0] OP_RSUB  = 4'd1;
   localparam logic [OP_W-1:0] OP_AND   = 4'd2;
   localparam logic [OP_W-1:0] OP_OR    = 4'd3;
   localparam logic [OP_W-1:0] OP_XOR   = 4'd4;
   localparam logic [OP_W-1:0] OP_NOT   = 4'd5;
   localparam logic [OP_W-1:0] OP_INC   = 4'd6;
   localparam logic [OP_W-1:0] OP_DEC   = 4'd7;
   localparam logic [OP_W-1:0] OP_INCSK = 4'd8;
   localparam logic [OP_W-1:0] OP_DECSK = 4'd9;
   localparam logic [OP_W-1:0] OP_ROTL  = 4'd10;
   localparam logic [OP_W-1:0] OP_ROTR  = 4'd11;
   localparam logic [OP_W-1:0] OP_SWAP  = 4'd12;
   localparam logic [OP_W-1:0] OP_DADJ  = 4'd13;

   typedef struct packed {
      logic c;
      logic dc;
      logic z;
   } flags_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o,
   output logic              dc_o
);
   localparam int NIB_W = DATA_W / 2;

   logic [DATA_W:0]  add_full;
   logic [NIB_W:0]   add_nib;
   logic [DATA_W-1:0] inc_v, dec_v, sub_v;

   assign add_full = {1'b0, a_i} + {1'b0, b_i};
   assign add_nib  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]};
   assign sub_v    = b_i - a_i;
   assign inc_v    = b_i + {{(DATA_W-1){1'b0}}, 1'b1};
   assign dec_v    = b_i - {{(DATA_W-1){1'b0}}, 1'b1};

   always_comb begin
      res_o = add_full[DATA_W-1:0];
      c_o   = add_full[DATA_W];
      dc_o  = add_nib[NIB_W];
      case (op_i)
         OP_RSUB: begin
            res_o = sub_v;
            c_o   = (b_i >= a_i);
            dc_o  = (b_i[NIB_W-1:0] >= a_i[NIB_W-1:0]);
         end
         OP_INC, OP_INCSK: res_o = inc_v;
         OP_DEC, OP_DECSK: res_o = dec_v;
         default: ;
      endcase
   end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              c_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o
);
   localparam int NIB_W = DATA_W / 2;

   always_comb begin
      res_o = b_i;
      c_o   = c_i;
      case (op_i)
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         OP_NOT:  res_o = ~b_i;
         OP_ROTL: begin
            res_o = {b_i[DATA_W-2:0], c_i};
            c_o   = b_i[DATA_W-1];
         end
         OP_ROTR: begin
            res_o = {c_i, b_i[DATA_W-1:1]};
            c_o   = b_i[0];
         end
         OP_SWAP: res_o = {b_i[NIB_W-1:0], b_i[DATA_W-1:NIB_W]};
         default: ;
      endcase
   end
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic              c_i,
   input  logic              dc_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o
);
   localparam int NIB_W = DATA_W / 2;
   localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
   localparam logic [DATA_W:0]   LO_FIX = (DATA_W+1)'(6);
   localparam logic [DATA_W:0]   HI_FIX = (DATA_W+1)'(6) << NIB_W;

   logic            lo_adj, hi_adj;
   logic [DATA_W:0] step1, step2;

   assign lo_adj = (a_i[NIB_W-1:0] > DIGIT_MAX) || dc_i;
   assign step1  = {1'b0, a_i} + (lo_adj ? LO_FIX : '0);
   assign hi_adj = (step1[DATA_W-1:NIB_W] > DIGIT_MAX) || c_i;
   assign step2  = {1'b0, step1[DATA_W-1:0]} + (hi_adj ? HI_FIX : '0);
   assign res_o  = step2[DATA_W-1:0];
   assign c_o    = c_i | step1[DATA_W] | step2[DATA_W];
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
   import alu8_pkg::*;
#(
   parameter bit REG_FLAGS = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  flags_t d_i,
   output flags_t q_o
);
   generate
      if (REG_FLAGS) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o <= '0;
            else        q_o <= d_i;
         end
      end else begin : g_wire
         assign q_o = d_i;
      end
   endgenerate
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
   import alu8_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit REG_FLAGS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic              c_i,
   input  logic              dc_i,
   input  logic              z_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o,
   output logic              dc_o,
   output logic              z_o,
   output logic              skip_o,
   output logic              fq_c_o,
   output logic              fq_dc_o,
   output logic              fq_z_o
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("acc_alu8: decimal adjust needs DATA_W == 8");
      end
   endgenerate

   logic [DATA_W-1:0] ar_res, lg_res, bcd_res;
   logic              ar_c, ar_dc, lg_c, bcd_c;
   logic              res_zero;
   flags_t            nxt, fq;

   alu8_arith #(.DATA_W(DATA_W)) u_arith (
      .op_i (op_i), .a_i (acc_i), .b_i (opnd_i),
      .res_o(ar_res), .c_o (ar_c), .dc_o (ar_dc)
   );

   alu8_logic #(.DATA_W(DATA_W)) u_logic (
      .op_i (op_i), .a_i (acc_i), .b_i (opnd_i), .c_i (c_i),
      .res_o(lg_res), .c_o (lg_c)
   );

   alu8_bcd #(.DATA_W(DATA_W)) u_bcd (
      .a_i (acc_i), .c_i (c_i), .dc_i (dc_i),
      .res_o(bcd_res), .c_o (bcd_c)
   );

   assign res_zero = (res_o == '0);

   always_comb begin
      res_o  = acc_i;
      nxt.c  = c_i;
      nxt.dc = dc_i;
      nxt.z  = z_i;
      skip_o = 1'b0;
      case (op_i)
         OP_ADD, OP_RSUB: begin
            res_o  = ar_res;
            nxt.c  = ar_c;
            nxt.dc = ar_dc;
            nxt.z  = res_zero;
         end
         OP_AND, OP_OR, OP_XOR, OP_NOT: begin
            res_o = lg_res;
            nxt.z = res_zero;
         end
         OP_INC, OP_DEC: begin
            res_o = ar_res;
            nxt.z = res_zero;
         end
         OP_INCSK, OP_DECSK: begin
            res_o  = ar_res;
            skip_o = res_zero;
         end
         OP_ROTL, OP_ROTR: begin
            res_o = lg_res;
            nxt.c = lg_c;
         end
         OP_SWAP: res_o = lg_res;
         OP_DADJ: begin
            res_o = bcd_res;
            nxt.c = bcd_c;
         end
         default: ;
      endcase
   end

   assign c_o  = nxt.c;
   assign dc_o = nxt.dc;
   assign z_o  = nxt.z;

   alu8_flagreg #(.REG_FLAGS(REG_FLAGS)) u_freg (
      .clk(clk), .rst_n(rst_n), .d_i(nxt), .q_o(fq)
   );

   assign fq_c_o  = fq.c;
   assign fq_dc_o = fq.dc;
   assign fq_z_o  = fq.z;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
   import alu8_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit REG_FLAGS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [OP_W-1:0]   op_i,
   input logic [DATA_W-1:0] acc_i,
   input logic [DATA_W-1:0] opnd_i,
   input logic              c_i,
   input logic              dc_i,
   input logic              z_i,
   input logic [DATA_W-1:0] res_o,
   input logic              c_o,
   input logic              dc_o,
   input logic              z_o,
   input logic              skip_o,
   input logic              fq_c_o,
   input logic              fq_dc_o,
   input logic              fq_z_o
);
   logic is_logic;
   assign is_logic = (op_i == OP_AND) || (op_i == OP_OR) ||
                     (op_i == OP_XOR) || (op_i == OP_NOT);

   assert_logic_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      is_logic |-> (c_o == c_i) && (dc_o == dc_i) && (z_o == (res_o == '0)));

   assert_skip_keeps_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_INCSK || op_i == OP_DECSK) |->
         (skip_o == (res_o == '0)) && (c_o == c_i) && (dc_o == dc_i) && (z_o == z_i));

   assert_rotl_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_ROTL) |-> (c_o == opnd_i[DATA_W-1]) && (res_o[0] == c_i));

   assert_swap_no_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_SWAP) |-> (c_o == c_i) && (dc_o == dc_i) && (z_o == z_i));

   assert_dadj_carry_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_DADJ && c_i) |-> c_o);

   assert_skip_only_skip_ops_R11: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |-> (op_i == OP_INCSK || op_i == OP_DECSK));

   generate
      if (REG_FLAGS) begin : g_reg_chk
         assert_flag_copy_R12: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (fq_c_o == $past(c_o)) && (fq_dc_o == $past(dc_o)) &&
                     (fq_z_o == $past(z_o)));
      end
   endgenerate
endmodule

bind acc_alu8 alu8_chk #(.DATA_W(DATA_W), .REG_FLAGS(REG_FLAGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
   .c_i(c_i), .dc_i(dc_i), .z_i(z_i), .res_o(res_o), .c_o(c_o),
   .dc_o(dc_o), .z_o(z_o), .skip_o(skip_o), .fq_c_o(fq_c_o),
   .fq_dc_o(fq_dc_o), .fq_z_o(fq_z_o)
);

// File: tb/sim_acc_alu8.sv
module sim_acc_alu8;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_i = '0;
   logic [7:0] acc_i = '0, opnd_i = '0;
   logic       c_i = 1'b0, dc_i = 1'b0, z_i = 1'b0;
   logic [7:0] res_o;
   logic       c_o, dc_o, z_o, skip_o, fq_c_o, fq_dc_o, fq_z_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [2:0] prev_flags;
   bit prev_valid = 1'b0;

   always #4 clk = ~clk;

   acc_alu8 u0 (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
      .c_i(c_i), .dc_i(dc_i), .z_i(z_i), .res_o(res_o), .c_o(c_o),
      .dc_o(dc_o), .z_o(z_o), .skip_o(skip_o), .fq_c_o(fq_c_o),
      .fq_dc_o(fq_dc_o), .fq_z_o(fq_z_o)
   );

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd0: return "R1";
         4'd1: return "R2";
         4'd2, 4'd3, 4'd4, 4'd5: return "R3";
         4'd6, 4'd7: return "R4";
         4'd8, 4'd9: return "R5";
         4'd10, 4'd11: return "R6";
         4'd12: return "R7";
         4'd13: return "R8/R9";
         default: return "R10";
      endcase
   endfunction

   // expected {skip, c, dc, z, res}
   function automatic logic [11:0] model(input logic [3:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic ci,
                                         input logic dci, input logic zi);
      logic [7:0] r;
      logic c, dc, z, sk;
      int t;
      r = a; c = ci; dc = dci; z = zi; sk = 1'b0;
      case (op)
         4'd0: begin t = a + b; r = t[7:0]; c = (t > 255);
                     dc = ((a % 16) + (b % 16)) > 15; z = (r == 0); end
         4'd1: begin r = b - a; c = (b >= a); dc = (b % 16) >= (a % 16); z = (r == 0); end
         4'd2: begin r = a & b; z = (r == 0); end
         4'd3: begin r = a | b; z = (r == 0); end
         4'd4: begin r = a ^ b; z = (r == 0); end
         4'd5: begin r = ~b; z = (r == 0); end
         4'd6: begin r = b + 8'd1; z = (r == 0); end
         4'd7: begin r = b - 8'd1; z = (r == 0); end
         4'd8: begin r = b + 8'd1; sk = (r == 0); end
         4'd9: begin r = b - 8'd1; sk = (r == 0); end
         4'd10: begin r = {b[6:0], ci}; c = b[7]; end
         4'd11: begin r = {ci, b[7:1]}; c = b[0]; end
         4'd12: r = {b[3:0], b[7:4]};
         4'd13: begin
            t = a;
            if ((a % 16) > 9 || dci) t = t + 6;
            if (t > 255) c = 1'b1;
            t = t % 256;
            if ((t / 16) > 9 || ci) t = t + 96;
            if (t > 255) c = 1'b1;
            r = t[7:0];
         end
         default: ;
      endcase
      return {sk, c, dc, z, r};
   endfunction

   task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic ci, input logic dci, input logic zi);
      logic [11:0] e;
      @(negedge clk);
      if (prev_valid) begin
         checks++;
         if ({fq_c_o, fq_dc_o, fq_z_o} !== prev_flags) begin
            errors++;
            $display("FAIL R12 registered flags act=%b exp=%b",
                     {fq_c_o, fq_dc_o, fq_z_o}, prev_flags);
         end
      end
      op_i = op; acc_i = a; opnd_i = b; c_i = ci; dc_i = dci; z_i = zi;
      #1;
      e = model(op, a, b, ci, dci, zi);
      checks++;
      if ({skip_o, c_o, dc_o, z_o, res_o} !== e) begin
         errors++;
         $display("FAIL %s op=%0d acc=%h opnd=%h c=%b dc=%b z=%b act={sk,c,dc,z,res}=%b_%b%b%b_%h exp=%b_%b%b%b_%h",
                  req_of(op), op, a, b, ci, dci, zi, skip_o, c_o, dc_o, z_o, res_o,
                  e[11], e[10], e[9], e[8], e[7:0]);
      end
      if (op != 4'd8 && op != 4'd9) begin
         checks++;
         if (skip_o !== 1'b0) begin
            errors++;
            $display("FAIL R11 skip on op=%0d act=%b exp=0", op, skip_o);
         end
      end
      prev_flags = e[10:8];
      prev_valid = 1'b1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired act=running exp=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      // R12: reset state of the flag copy
      op_i = 4'd0; acc_i = 8'hFF; opnd_i = 8'h01;
      #1;
      checks++;
      if ({fq_c_o, fq_dc_o, fq_z_o} !== 3'b000) begin
         errors++;
         $display("FAIL R12 reset flags act=%b exp=000", {fq_c_o, fq_dc_o, fq_z_o});
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R1 directed: byte and nibble carry, zero
      apply(4'd0, 8'hFF, 8'h01, 0, 0, 0);
      apply(4'd0, 8'h08, 8'h08, 0, 0, 1);
      apply(4'd0, 8'h70, 8'h10, 1, 1, 1);
      // R2 directed: equal, borrow, nibble borrow
      apply(4'd1, 8'h05, 8'h05, 0, 0, 0);
      apply(4'd1, 8'h01, 8'h00, 1, 1, 0);
      apply(4'd1, 8'h0F, 8'h30, 0, 0, 1);
      // R3 directed
      apply(4'd2, 8'hAA, 8'h55, 1, 0, 0);
      apply(4'd5, 8'h00, 8'hFF, 0, 1, 0);
      // R4 wrap
      apply(4'd6, 8'h00, 8'hFF, 1, 1, 0);
      apply(4'd7, 8'h00, 8'h00, 0, 0, 1);
      // R5 skip edges
      apply(4'd8, 8'h00, 8'hFF, 0, 1, 0);
      apply(4'd9, 8'h00, 8'h01, 1, 0, 0);
      apply(4'd9, 8'h00, 8'h02, 1, 0, 1);
      // R6, R7
      apply(4'd10, 8'h00, 8'h80, 0, 0, 0);
      apply(4'd11, 8'h00, 8'h01, 1, 0, 0);
      apply(4'd12, 8'h00, 8'hF0, 1, 1, 1);
      // R8, R9 decimal adjust corners
      apply(4'd13, 8'h9A, 8'h00, 0, 0, 0);
      apply(4'd13, 8'h12, 8'h00, 0, 1, 0);
      apply(4'd13, 8'h45, 8'h00, 1, 0, 0);
      apply(4'd13, 8'hFA, 8'h00, 0, 0, 1);
      apply(4'd13, 8'h99, 8'h00, 0, 0, 0);
      // R10 reserved
      apply(4'd14, 8'h3C, 8'hC3, 1, 0, 1);
      apply(4'd15, 8'h00, 8'h11, 0, 1, 0);

      for (int i = 0; i < 4000; i++) begin
         logic [3:0] op;
         logic [7:0] a, b;
         logic [2:0] f;
         op = 4'($urandom_range(0, 15));
         a  = 8'($urandom);
         b  = 8'($urandom);
         f  = 3'($urandom);
         if (i % 16 == 0) b = 8'h01;
         if (i % 16 == 1) b = 8'hFF;
         apply(op, a, b, f[2], f[1], f[0]);
      end
      @(negedge clk);
      checks++;
      if ({fq_c_o, fq_dc_o, fq_z_o} !== prev_flags) begin
         errors++;
         $display("FAIL R12 registered flags act=%b exp=%b",
                  {fq_c_o, fq_dc_o, fq_z_o}, prev_flags);
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule